// File: doc/BRIEF.md
# Sequential Signed Double-Word Divider

This block divides a signed double-length dividend by a single signed word and returns a truncated quotient and a remainder. The dividend is split across two words. The high word `a_in` carries the sign and the upper magnitude bits. The low word `b_in` supplies the lower bits, and its top bit plays no part in the value. The divisor word arrives on `div_in`. A one-cycle `start` pulse launches an operation. When the results are ready, the quotient appears on `b_out` and the remainder on `a_out`, and `done` pulses high for one cycle.

The block works on magnitudes, two quotient bits per cycle. Signed inputs are made positive first, and the results are given their signs afterwards. Each of these sign fixes takes one extra cycle, so the latency depends on the operand signs.

A mode input selects 16-bit words or 18-bit words. If the high word is already too large for the divisor, the block reports overflow and does not run the division.

Top module: `split_sign_divider`

## Requirements
- R1: In 16-bit mode (`wide`=0) the dividend is the 31-bit two's-complement value formed by a_in[15:0] followed by b_in[14:0]; b_in[15] and the upper input bits have no effect on any output.
- R2: The quotient is the dividend divided by the sign-extended divisor, truncated toward zero. It is written to `b_out` as a two's-complement word of the mode width, and the output bits above the mode width read zero.
- R3: The remainder is written to `a_out` as a two's-complement word of the mode width. It takes the sign of the dividend, its magnitude is below that of the divisor, and dividend = quotient × divisor + remainder.
- R4: When |a| ≥ |divisor|, with both sign-extended from the mode width (a zero divisor always qualifies), `ovf` is 1 and `a_out`/`b_out` return `a_in`/`b_in` masked to the mode width. Otherwise `ovf` is 0.
- R5: Counting the rising edge that samples `start` as edge 1, `done` is high after edge L. Without overflow, L = base + n + m + (n xor m) + n, where n is 1 for a negative high word, m is 1 for a negative divisor, and base is 10 in 16-bit mode and 11 in 18-bit mode. With overflow, L = 2.
- R6: `done` is high for exactly one cycle per operation. `a_out`, `b_out` and `ovf` change only on the edge that raises `done`, and otherwise hold their values.
- R7: A `start` pulse that arrives while an operation is in progress is ignored. It neither alters the running result nor causes an extra `done`.
- R8: In 18-bit mode (`wide`=1) the dividend is the 35-bit two's-complement value formed by a_in[17:0] followed by b_in[16:0]; b_in[17] is ignored. R2 to R4 apply with 18-bit words.
- R9: After a synchronous reset, `done`, `ovf`, `a_out` and `b_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle launch pulse, honoured only when the block is idle |
| wide | input | 1 | Word width select: 0 for 16 bits, 1 for 18 bits |
| a_in | input | 18 | Dividend high word, carrying the sign |
| b_in | input | 18 | Dividend low word; its top bit in the mode is ignored |
| div_in | input | 18 | Divisor word |
| a_out | output | 18 | Remainder, or `a_in` on overflow |
| b_out | output | 18 | Quotient, or `b_in` on overflow |
| ovf | output | 1 | Overflow flag of the last completed operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
Different internal faults show up at the ports in different ways, but each shows up by the first `done` of an affected operation.

A wrong sign flag or a wrong sign-fix step shows in two ways: the pulse arrives on a different cycle from the one R5 predicts, and `b_out` or `a_out` has the wrong sign. A damaged partial remainder or iteration count corrupts the quotient bits, so the check of dividend = quotient × divisor + remainder fails on that `done`.

A controller that leaves its idle state, or re-arms on a `start` it should ignore, shows up as a second `done` that R7 forbids. It can also show up as a change to `a_out` at a time other than the `done` edge.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

    // Widest word handled, the narrow mode width, and quotient bits retired per cycle.
    parameter int unsigned MAXW      = 18;
    parameter int unsigned NARW      = 16;
    parameter int unsigned STEP_BITS = 2;

    // Partial-remainder width: two bits of headroom over the widest word.
    localparam int unsigned RW        = MAXW + 2;
    // Joined dividend width: remainder field plus quotient field.
    localparam int unsigned JW        = RW + MAXW;
    localparam int unsigned ITER_NAR  = (NARW + STEP_BITS - 1) / STEP_BITS;
    localparam int unsigned ITER_WIDE = (MAXW + STEP_BITS - 1) / STEP_BITS;
    localparam int unsigned CNT_W     = $clog2(ITER_WIDE + 1);
    localparam int unsigned PAD       = MAXW - NARW;

    typedef logic [MAXW-1:0] word_t;
    typedef logic [RW-1:0]   rem_t;
    typedef logic [MAXW-1:0] quo_t;
    typedef logic [JW-1:0]   joint_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NDVD,
        ST_NDVS,
        ST_ITER,
        ST_NQUO,
        ST_NREM,
        ST_FIN
    } state_t;

    // Shift/subtract working pair: partial remainder above, quotient below.
    typedef struct packed {
        rem_t rem;
        quo_t quo;
    } work_t;

    // Sign-extend a word of the selected width to remainder width.
    function automatic rem_t sext_word(word_t v, logic wide);
        if (wide)
            return {{(RW-MAXW){v[MAXW-1]}}, v};
        return {{(RW-NARW){v[NARW-1]}}, v[NARW-1:0]};
    endfunction

    function automatic rem_t mag(rem_t x);
        return x[RW-1] ? rem_t'(-x) : x;
    endfunction

    // Zero the bits above the mode width.
    function automatic word_t mask_word(word_t v, logic wide);
        if (wide)
            return v;
        return {{PAD{1'b0}}, v[NARW-1:0]};
    endfunction

    // Build the signed dividend from the split-sign pair, low-word sign bit dropped.
    function automatic joint_t load_joint(word_t a, word_t b, logic wide);
        if (wide)
            return {{(JW-2*MAXW+1){a[MAXW-1]}}, a, b[MAXW-2:0]};
        return {{(JW-2*NARW+1){a[NARW-1]}}, a[NARW-1:0], b[NARW-2:0]};
    endfunction

    // Rejoin the working pair into one signed dividend value.
    function automatic joint_t join_work(work_t w, logic wide);
        if (wide)
            return {w.rem, w.quo};
        return {{(JW-RW-NARW){w.rem[RW-1]}}, w.rem, w.quo[MAXW-1 -: NARW]};
    endfunction

    // Split a dividend so the low field sits left-aligned in the quotient slot.
    function automatic work_t split_work(joint_t j, logic wide);
        work_t w;
        if (wide) begin
            w.rem = j[JW-1 -: RW];
            w.quo = j[MAXW-1:0];
        end else begin
            w.rem = j[NARW +: RW];
            w.quo = {j[NARW-1:0], {PAD{1'b0}}};
        end
        return w;
    endfunction

endpackage

// File: rtl/sdd_ovf_check.sv
module sdd_ovf_check
    import sdd_pkg::*;
(
    input  word_t a_word,
    input  word_t d_word,
    input  logic  wide,
    output logic  dvd_neg,
    output logic  dvs_neg,
    output logic  too_big
);
    rem_t a_sx;
    rem_t d_sx;

    assign a_sx    = sext_word(a_word, wide);
    assign d_sx    = sext_word(d_word, wide);
    assign dvd_neg = a_sx[RW-1];
    assign dvs_neg = d_sx[RW-1];
    // The high word must stay below the divisor for the quotient to fit.
    assign too_big = (mag(a_sx) >= mag(d_sx));

endmodule

// File: rtl/sdd_radix_step.sv
module sdd_radix_step
    import sdd_pkg::*;
(
    input  work_t cur,
    input  rem_t  dvs,
    output work_t nxt
);
    // STEP_BITS restoring shift/subtract stages chained in one cycle.
    always_comb begin
        work_t w;
        rem_t  sh;
        w = cur;
        for (int k = 0; k < int'(STEP_BITS); k++) begin
            sh    = {w.rem[RW-2:0], w.quo[MAXW-1]};
            w.quo = {w.quo[MAXW-2:0], 1'b0};
            if (sh >= dvs) begin
                w.rem    = sh - dvs;
                w.quo[0] = 1'b1;
            end else begin
                w.rem = sh;
            end
        end
        nxt = w;
    end

endmodule

// File: rtl/sdd_ctrl.sv
module sdd_ctrl
    import sdd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   wide,
    input  logic   ovf_det,
    input  logic   dvd_neg,
    input  logic   dvs_neg,
    output state_t state,
    output logic   wide_q,
    output logic   ovf_q
);
    cnt_t cnt;
    logic dvd_neg_q;
    logic dvs_neg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            wide_q    <= 1'b0;
            ovf_q     <= 1'b0;
            dvd_neg_q <= 1'b0;
            dvs_neg_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        wide_q    <= wide;
                        ovf_q     <= ovf_det;
                        dvd_neg_q <= dvd_neg;
                        dvs_neg_q <= dvs_neg;
                        cnt       <= wide ? cnt_t'(ITER_WIDE - 1) : cnt_t'(ITER_NAR - 1);
                        if (ovf_det)      state <= ST_FIN;
                        else if (dvd_neg) state <= ST_NDVD;
                        else if (dvs_neg) state <= ST_NDVS;
                        else              state <= ST_ITER;
                    end
                end
                ST_NDVD: state <= dvs_neg_q ? ST_NDVS : ST_ITER;
                ST_NDVS: state <= ST_ITER;
                ST_ITER: begin
                    if (cnt == '0) begin
                        if (dvd_neg_q ^ dvs_neg_q) state <= ST_NQUO;
                        else if (dvd_neg_q)        state <= ST_NREM;
                        else                       state <= ST_FIN;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_NQUO: state <= dvd_neg_q ? ST_NREM : ST_FIN;
                ST_NREM: state <= ST_FIN;
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: completion hands control straight back to idle.
    p_fin_to_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN) |=> (state == ST_IDLE));

    // R7: a start seen mid-operation must not reload the captured context.
    p_busy_keeps_ctx_r7: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> ($stable(wide_q) && $stable(dvd_neg_q) && $stable(dvs_neg_q)));

endmodule

// File: rtl/split_sign_divider.sv
module split_sign_divider
    import sdd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wide,
    input  logic [MAXW-1:0]   a_in,
    input  logic [MAXW-1:0]   b_in,
    input  logic [MAXW-1:0]   div_in,
    output logic [MAXW-1:0]   a_out,
    output logic [MAXW-1:0]   b_out,
    output logic              ovf,
    output logic              done
);
    state_t state;
    logic   wide_q;
    logic   ovf_q;
    logic   ovf_det;
    logic   dvd_neg;
    logic   dvs_neg;
    work_t  work_q;
    work_t  step_out;
    rem_t   dvs_q;

    sdd_ovf_check u_ovf (
        .a_word  (a_in),
        .d_word  (div_in),
        .wide    (wide),
        .dvd_neg (dvd_neg),
        .dvs_neg (dvs_neg),
        .too_big (ovf_det)
    );

    sdd_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .wide    (wide),
        .ovf_det (ovf_det),
        .dvd_neg (dvd_neg),
        .dvs_neg (dvs_neg),
        .state   (state),
        .wide_q  (wide_q),
        .ovf_q   (ovf_q)
    );

    sdd_radix_step u_step (
        .cur (work_q),
        .dvs (dvs_q),
        .nxt (step_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            dvs_q  <= '0;
            a_out  <= '0;
            b_out  <= '0;
            ovf    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        dvs_q <= sext_word(div_in, wide);
                        if (ovf_det) begin
                            work_q.rem <= {{(RW-MAXW){1'b0}}, mask_word(a_in, wide)};
                            work_q.quo <= mask_word(b_in, wide);
                        end else begin
                            work_q <= split_work(load_joint(a_in, b_in, wide), wide);
                        end
                    end
                end
                ST_NDVD: work_q <= split_work(joint_t'(-join_work(work_q, wide_q)), wide_q);
                ST_NDVS: dvs_q <= rem_t'(-dvs_q);
                ST_ITER: work_q <= step_out;
                ST_NQUO: work_q.quo <= quo_t'(-work_q.quo);
                ST_NREM: work_q.rem <= rem_t'(-work_q.rem);
                ST_FIN: begin
                    a_out <= mask_word(work_q.rem[MAXW-1:0], wide_q);
                    b_out <= mask_word(work_q.quo, wide_q);
                    ovf   <= ovf_q;
                    done  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R3: the partial remainder stays below the divisor magnitude throughout iteration.
    p_rem_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ITER) |-> (work_q.rem < dvs_q));

    // R6: completion is a single-cycle pulse.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: results and flag only move on the edge that raises done.
    p_hold_results_r6: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(a_out) && $stable(b_out) && $stable(ovf)));

    // R4: a flagged overflow leaves the remainder field with no bits above the word.
    p_ovf_word_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN && ovf_q) |-> (work_q.rem[RW-1:MAXW] == '0));

endmodule

// File: tb/split_sign_divider_test.sv
`timescale 1ns/1ps
module split_sign_divider_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        wide;
    logic [17:0] a_in, b_in, div_in;
    logic [17:0] a_out, b_out;
    logic        ovf, done;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    split_sign_divider uut (
        .clk(clk), .rst(rst), .start(start), .wide(wide),
        .a_in(a_in), .b_in(b_in), .div_in(div_in),
        .a_out(a_out), .b_out(b_out), .ovf(ovf), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint sx(input longint v, input int w);
        longint m;
        m = (64'sd1 <<< w) - 1;
        v = v & m;
        return v[w-1] ? v - (64'sd1 <<< w) : v;
    endfunction

    function automatic longint labs(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    // Launch one operation and return the number of edges until done is seen.
    task automatic run_op(input logic [17:0] a, input logic [17:0] b,
                          input logic [17:0] d, input logic w, output int cyc);
        @(negedge clk);
        a_in = a; b_in = b; div_in = d; wide = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // Full check of one operation against the requirement model.
    task automatic do_op(input logic [17:0] a, input logic [17:0] b,
                         input logic [17:0] d, input logic w, input string req);
        int     wd, cyc, lat;
        longint as_, ds, dvd, q, r, msk, ea, eb;
        bit     an, dn, eo;
        wd  = w ? 18 : 16;
        msk = (64'sd1 <<< wd) - 1;
        as_ = sx(longint'(a), wd);
        ds  = sx(longint'(d), wd);
        an  = as_ < 0;
        dn  = ds < 0;
        dvd = as_ * (64'sd1 <<< (wd - 1)) + (longint'(b) & ((64'sd1 <<< (wd - 1)) - 1));
        eo  = labs(as_) >= labs(ds);
        if (eo) begin
            ea = longint'(a) & msk; eb = longint'(b) & msk; lat = 2;
        end else begin
            q  = dvd / ds;
            r  = dvd % ds;
            ea = r & msk; eb = q & msk;
            lat = (w ? 11 : 10) + int'(an) + int'(dn) + int'(an ^ dn) + int'(an);
        end
        run_op(a, b, d, w, cyc);
        chk(done === 1'b1, "R5", {req, " done seen"}, longint'(done), 1);
        chk(cyc == lat, "R5", {req, " latency"}, cyc, lat);
        chk(ovf === eo, "R4", {req, " ovf flag"}, longint'(ovf), longint'(eo));
        chk(longint'(b_out) == eb, eo ? "R4" : "R2", {req, " b_out"}, longint'(b_out), eb);
        chk(longint'(a_out) == ea, eo ? "R4" : "R3", {req, " a_out"}, longint'(a_out), ea);
        @(negedge clk);
        chk(done === 1'b0, "R6", {req, " done pulse width"}, longint'(done), 0);
    endtask

    task automatic t_reset;
        chk(done === 1'b0, "R9", "reset done", longint'(done), 0);
        chk(ovf === 1'b0, "R9", "reset ovf", longint'(ovf), 0);
        chk(a_out === 18'd0, "R9", "reset a_out", longint'(a_out), 0);
        chk(b_out === 18'd0, "R9", "reset b_out", longint'(b_out), 0);
    endtask

    task automatic t_basic16;
        do_op(18'h00001, 18'h00000, 18'h00003, 1'b0, "R2 pos/pos");
        do_op(18'h00123, 18'h04567, 18'h07001, 1'b0, "R3 pos/pos large");
        do_op(18'h00000, 18'h00005, 18'h00007, 1'b0, "R2 small dividend");
    endtask

    task automatic t_signs16;
        do_op(18'h0FFFF, 18'h00005, 18'h00007, 1'b0, "R3 neg/pos");
        do_op(18'h00002, 18'h01234, 18'h0FC18, 1'b0, "R2 pos/neg");
        do_op(18'h0FF00, 18'h07FFF, 18'h0F000, 1'b0, "R3 neg/neg");
        do_op(18'h07FFF, 18'h07FFF, 18'h08000, 1'b0, "R2 most negative divisor");
        do_op(18'h00000, 18'h00000, 18'h0FFF0, 1'b0, "R5 zero dividend neg divisor");
    endtask

    task automatic t_overflow;
        do_op(18'h00005, 18'h01111, 18'h00005, 1'b0, "R4 equal magnitude");
        do_op(18'h00000, 18'h0ABCD, 18'h00000, 1'b0, "R4 zero divisor");
        do_op(18'h08000, 18'h00001, 18'h08000, 1'b0, "R4 both most negative");
        do_op(18'h3FFF0, 18'h3ABCD, 18'h00004, 1'b1, "R4 wide overflow");
    endtask

    // R1: the low word's sign position and upper bits must not matter.
    task automatic t_ignore16;
        logic [17:0] a1, b1;
        int cyc;
        run_op(18'h00321, 18'h01357, 18'h01000, 1'b0, cyc);
        a1 = a_out; b1 = b_out;
        run_op(18'h30321, 18'h3937F & 18'h3FFFF ^ 18'h00028, 18'h31000, 1'b0, cyc);
        chk(a_out == a1, "R1", "b15/upper ignored a_out", longint'(a_out), longint'(a1));
        chk(b_out == b1, "R1", "b15/upper ignored b_out", longint'(b_out), longint'(b1));
        do_op(18'h00321, 18'h09357, 18'h01000, 1'b0, "R1 b15 set");
    endtask

    task automatic t_wide;
        do_op(18'h00123, 18'h1ABCD, 18'h0F000, 1'b1, "R8 wide pos/pos");
        do_op(18'h3FFFF, 18'h00009, 18'h00005, 1'b1, "R8 wide neg/pos");
        do_op(18'h01000, 18'h3FFFF, 18'h20001, 1'b1, "R8 wide b17 set neg divisor");
        do_op(18'h3F000, 18'h12345, 18'h3E000, 1'b1, "R8 wide neg/neg");
    endtask

    // R7 and R6: mid-operation start ignored; outputs hold until done.
    task automatic t_busy;
        logic [17:0] prev_a;
        int cyc;
        bit extra;
        run_op(18'h00010, 18'h00000, 18'h00100, 1'b0, cyc);
        prev_a = a_out;
        @(negedge clk);
        a_in = 18'h00001; b_in = 18'h00000; div_in = 18'h00003; wide = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        a_in = 18'h0FFFF; b_in = 18'h00001; div_in = 18'h0FFFE; wide = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(a_out == prev_a, "R6", "a_out held while busy", longint'(a_out), longint'(prev_a));
        cyc = 4;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 10, "R7", "latency unchanged by busy start", cyc, 10);
        chk(b_out == 18'd10922, "R7", "quotient of first op", longint'(b_out), 10922);
        chk(a_out == 18'd2, "R7", "remainder of first op", longint'(a_out), 2);
        extra = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) extra = 1'b1;
        end
        chk(!extra, "R7", "no second done", longint'(extra), 0);
        chk(a_out == 18'd2, "R6", "a_out held when idle", longint'(a_out), 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; wide = 1'b0;
        a_in = '0; b_in = '0; div_in = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic16();
        t_signs16();
        t_overflow();
        t_ignore16();
        t_wide();
        t_busy();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule